// File: doc/BRIEF.md
# Exception Escalation Fault Classifier

This block sits between the sources of hardware exceptions and the handler dispatch of a processor core. It remembers which exception is currently being delivered. For each new exception it decides one of three outcomes: the exception is delivered as it is, it is promoted to a double fault (vector 8), or it becomes a shutdown because a fault arrived while a double fault was still being delivered.

A request is one cycle of `in_valid` carrying a vector, an error code and a flag that marks a software interrupt. The decision appears one cycle later. A delivered exception raises `out_valid` for one cycle, together with the resulting vector and error code. A shutdown raises `out_shutdown` for one cycle instead. When the core has entered a handler successfully, it pulses `clr_pend`, and the remembered exception is forgotten.

Vectors fall into four classes. The contributory class is vector 0 and vectors 10 to 13. The page-fault class is vector 14. The double-fault class is vector 8. Every other vector is benign. The remembered exception has a "none" state of its own, which is separate from vector 0.

Top module: `exc_escalator`

## Requirements
- R1: After reset, `out_valid` and `out_shutdown` are 0 and nothing is remembered, so the first exception after reset, including vector 0, is delivered unchanged.
- R2: The contributory class is vectors 0, 10, 11, 12 and 13. A contributory exception that arrives while a contributory exception is remembered is delivered as vector 8 with error code 0.
- R3: While a page fault (vector 14) is remembered, a new page fault or a new contributory exception is delivered as vector 8 with error code 0.
- R4: A page fault that arrives while a contributory exception is remembered is delivered unchanged as vector 14, and vector 14 becomes the remembered exception.
- R5: Any exception that is not a software interrupt and arrives while vector 8 is remembered produces a one-cycle `out_shutdown` pulse with `out_valid` low, and the remembered state returns to none.
- R6: A benign vector (any vector other than 0, 8, 10 to 13 and 14) is delivered unchanged with its error code, and it leaves the remembered state as it was.
- R7: A request with `in_swint` = 1 is delivered with its vector and error code unchanged. It is never escalated or shut down, and it leaves the remembered state as it was.
- R8: `clr_pend` returns the remembered state to none. When `clr_pend` and `in_valid` are high in the same cycle, the new exception is classified against the cleared state.
- R9: Each result appears exactly one cycle after its `in_valid` cycle. `out_valid` and `out_shutdown` are 0 in any cycle that does not follow an `in_valid` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A new exception request is present this cycle |
| in_vector | input | VEC_W | Vector of the new exception |
| in_swint | input | 1 | The request is a software interrupt |
| in_err | input | ERR_W | Error code that comes with the request |
| clr_pend | input | 1 | The handler was entered, so the remembered exception is forgotten |
| out_valid | output | 1 | Pulse: a result is delivered |
| out_vector | output | VEC_W | Resulting vector |
| out_err | output | ERR_W | Resulting error code |
| out_shutdown | output | 1 | Pulse: triple-fault shutdown |

## Verification
Some properties can be checked on every cycle, and the assertions do so:
- the one-cycle latency and the quiet outputs when no request is present;
- delivery and shutdown never occurring in the same cycle;
- a shutdown lasting a single cycle;
- software interrupts passing through unchanged;
- a double fault promoted from another vector always carrying a zero error code;
- the clear strobe emptying the remembered state.

Other behaviour depends on the pairing of an earlier exception with a later one: which pairs escalate, and which leave the remembered state as it was. Only the bench's sweeps show this. The bench sweeps every pair from one earlier vector to one later vector over vectors 0 to 31, with and without the software-interrupt flag.

// File: rtl/exc_esc_pkg.sv
package exc_esc_pkg;
    localparam int unsigned DIV_VEC    = 0;
    localparam int unsigned DBL_VEC    = 8;
    localparam int unsigned PAGE_VEC   = 14;
    localparam int unsigned CGROUP_LO  = 10;
    localparam int unsigned CGROUP_HI  = 13;

    typedef enum logic [1:0] {
        CLS_BENIGN  = 2'd0,
        CLS_CONTRIB = 2'd1,
        CLS_PAGE    = 2'd2,
        CLS_DOUBLE  = 2'd3
    } exc_class_e;
endpackage

// File: rtl/exc_vec_decode.sv
module exc_vec_decode #(
    parameter int unsigned VEC_W = 8
) (
    input  logic [VEC_W-1:0]        vec,
    output exc_esc_pkg::exc_class_e cls
);
    import exc_esc_pkg::*;

    always_comb begin
        if (vec == VEC_W'(DIV_VEC) ||
            (vec >= VEC_W'(CGROUP_LO) && vec <= VEC_W'(CGROUP_HI)))
            cls = CLS_CONTRIB;
        else if (vec == VEC_W'(PAGE_VEC))
            cls = CLS_PAGE;
        else if (vec == VEC_W'(DBL_VEC))
            cls = CLS_DOUBLE;
        else
            cls = CLS_BENIGN;
    end
endmodule

// File: rtl/exc_classify.sv
module exc_classify #(
    parameter int unsigned VEC_W = 8,
    parameter int unsigned ERR_W = 32
) (
    input  logic             pend_valid,
    input  logic [VEC_W-1:0] pend_vec,
    input  logic [VEC_W-1:0] new_vec,
    input  logic             new_swint,
    input  logic [ERR_W-1:0] new_err,
    output logic [VEC_W-1:0] res_vec,
    output logic [ERR_W-1:0] res_err,
    output logic             res_shutdown,
    output logic             res_track
);
    import exc_esc_pkg::*;

    localparam int unsigned NUM_DEC = 2;

    logic [VEC_W-1:0] dec_in  [NUM_DEC];
    exc_class_e       dec_out [NUM_DEC];

    assign dec_in[0] = pend_vec;
    assign dec_in[1] = new_vec;

    for (genvar g = 0; g < NUM_DEC; g++) begin : g_dec
        exc_vec_decode #(.VEC_W(VEC_W)) u_dec (
            .vec (dec_in[g]),
            .cls (dec_out[g])
        );
    end

    logic pend_c, pend_p, pend_d, new_c, new_p, escalate;

    always_comb begin
        pend_c   = pend_valid && (dec_out[0] == CLS_CONTRIB);
        pend_p   = pend_valid && (dec_out[0] == CLS_PAGE);
        pend_d   = pend_valid && (dec_out[0] == CLS_DOUBLE);
        new_c    = (dec_out[1] == CLS_CONTRIB);
        new_p    = (dec_out[1] == CLS_PAGE);
        escalate = (pend_c && new_c) || (pend_p && (new_c || new_p));

        res_vec      = new_vec;
        res_err      = new_err;
        res_shutdown = 1'b0;
        res_track    = 1'b0;

        if (new_swint) begin
            res_track = 1'b0;
        end else if (pend_d) begin
            res_shutdown = 1'b1;
        end else if (escalate) begin
            res_vec   = VEC_W'(DBL_VEC);
            res_err   = '0;
            res_track = 1'b1;
        end else begin
            res_track = (dec_out[1] != CLS_BENIGN);
        end
    end
endmodule

// File: rtl/exc_escalator.sv
module exc_escalator #(
    parameter int unsigned VEC_W = 8,
    parameter int unsigned ERR_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [VEC_W-1:0] in_vector,
    input  logic             in_swint,
    input  logic [ERR_W-1:0] in_err,
    input  logic             clr_pend,
    output logic             out_valid,
    output logic [VEC_W-1:0] out_vector,
    output logic [ERR_W-1:0] out_err,
    output logic             out_shutdown
);
    import exc_esc_pkg::*;

    typedef struct packed {
        logic             out_valid;
        logic             out_shutdown;
        logic [VEC_W-1:0] out_vec;
        logic [ERR_W-1:0] out_err;
        logic             pend_valid;
        logic [VEC_W-1:0] pend_vec;
    } state_t;

    state_t state_d, state_q;

    logic             eff_valid;
    logic [VEC_W-1:0] cls_vec;
    logic [ERR_W-1:0] cls_err;
    logic             cls_shutdown, cls_track;

    assign eff_valid = state_q.pend_valid && !clr_pend;

    exc_classify #(.VEC_W(VEC_W), .ERR_W(ERR_W)) u_classify (
        .pend_valid   (eff_valid),
        .pend_vec     (state_q.pend_vec),
        .new_vec      (in_vector),
        .new_swint    (in_swint),
        .new_err      (in_err),
        .res_vec      (cls_vec),
        .res_err      (cls_err),
        .res_shutdown (cls_shutdown),
        .res_track    (cls_track)
    );

    always_comb begin
        state_d              = state_q;
        state_d.out_valid    = 1'b0;
        state_d.out_shutdown = 1'b0;
        state_d.pend_valid   = eff_valid;
        if (in_valid) begin
            if (cls_shutdown) begin
                state_d.out_shutdown = 1'b1;
                state_d.pend_valid   = 1'b0;
            end else begin
                state_d.out_valid = 1'b1;
                state_d.out_vec   = cls_vec;
                state_d.out_err   = cls_err;
                if (cls_track) begin
                    state_d.pend_valid = 1'b1;
                    state_d.pend_vec   = cls_vec;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign out_valid    = state_q.out_valid;
    assign out_shutdown = state_q.out_shutdown;
    assign out_vector   = state_q.out_vec;
    assign out_err      = state_q.out_err;

    assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_shutdown));

    assert_no_overlap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && out_shutdown));

    assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_shutdown |=> !out_shutdown);

    assert_swint_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_swint) |=> (out_valid && out_vector == $past(in_vector)
                                    && out_err == $past(in_err)));

    assert_promoted_err_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_swint && in_vector != VEC_W'(DBL_VEC))
        |=> ((out_valid && out_vector == VEC_W'(DBL_VEC)) -> out_err == '0));

    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_pend && !in_valid) |=> !state_q.pend_valid);
endmodule

// File: tb/exc_escalator_bench.sv
module exc_escalator_bench;
    localparam int VEC_W = 8;
    localparam int ERR_W = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [VEC_W-1:0] in_vector = '0;
    logic             in_swint = 1'b0;
    logic [ERR_W-1:0] in_err = '0;
    logic             clr_pend = 1'b0;
    logic             out_valid, out_shutdown;
    logic [VEC_W-1:0] out_vector;
    logic [ERR_W-1:0] out_err;

    int checks = 0;
    int errors = 0;

    bit m_valid = 0;
    int m_vec = 0;

    always #2.5ns clk = ~clk;

    exc_escalator #(.VEC_W(VEC_W), .ERR_W(ERR_W)) u_exc_escalator (
        .clk, .rst_n, .in_valid, .in_vector, .in_swint, .in_err, .clr_pend,
        .out_valid, .out_vector, .out_err, .out_shutdown
    );

    function automatic int cls(int v);
        if (v == 0 || (v >= 10 && v <= 13)) return 1;
        if (v == 14) return 2;
        if (v == 8) return 3;
        return 0;
    endfunction

    task automatic check(string tag, logic [41:0] act, logic [41:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got v=%0d s=%0d vec=%0d err=%h, expected v=%0d s=%0d vec=%0d err=%h",
                     tag, act[41], act[40], act[39:32], act[31:0],
                     exp[41], exp[40], exp[39:32], exp[31:0]);
        end
    endtask

    task automatic clear();
        @(negedge clk);
        clr_pend = 1'b1;
        @(negedge clk);
        clr_pend = 1'b0;
        m_valid = 0;
    endtask

    // Issue one request, predict the outcome from the requirements, compare.
    task automatic issue(int v, bit sw, logic [31:0] e, bit with_clr, string force_tag);
        bit ev, es; int evec; logic [31:0] eerr; string tag;
        int pc, nc;
        @(negedge clk);
        in_valid = 1'b1; in_vector = VEC_W'(v); in_swint = sw; in_err = e;
        clr_pend = with_clr;
        if (with_clr) m_valid = 0;
        pc = m_valid ? cls(m_vec) : -1;
        nc = cls(v);
        ev = 1; es = 0; evec = v; eerr = e; tag = "R6";
        if (sw) tag = "R7";
        else if (pc == 3) begin ev = 0; es = 1; m_valid = 0; tag = "R5"; end
        else if ((pc == 1 && nc == 1) || (pc == 2 && (nc == 1 || nc == 2))) begin
            evec = 8; eerr = 0; m_valid = 1; m_vec = 8;
            tag = (pc == 1) ? "R2" : "R3";
        end else if (nc != 0) begin
            m_valid = 1; m_vec = v;
            tag = (pc == 1 && nc == 2) ? "R4" : "R2";
        end
        if (force_tag != "") tag = force_tag;
        @(negedge clk);
        in_valid = 1'b0; clr_pend = 1'b0;
        if (ev) check(tag, {out_valid, out_shutdown, out_vector, out_err},
                      {1'b1, 1'b0, 8'(evec), eerr});
        else    check(tag, {out_valid, out_shutdown, 40'h0},
                      {1'b0, 1'b1, 40'h0});
    endtask

    initial begin
        #(5ns * 200000);
        errors++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", {out_valid, out_shutdown, 40'h0}, 42'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {out_valid, out_shutdown, 40'h0}, 42'h0);
        // R1: vector 0 straight after reset is not escalated
        issue(0, 0, 32'h11, 0, "R1");
        issue(10, 0, 32'h22, 0, "R2");
        // R9: idle cycle after a result
        @(negedge clk);
        check("R9", {out_valid, out_shutdown, 40'h0}, 42'h0);
        // R8: clear in the same cycle as a new contributory fault
        issue(13, 0, 32'h33, 1, "R8");
        issue(14, 0, 32'h44, 1, "R8");
        // R5: double fault pending then page fault -> shutdown
        issue(8, 0, 32'h0, 1, "R5");
        issue(14, 0, 32'h55, 0, "R5");
        issue(0, 0, 32'h66, 0, "R5");
        // Sweep every earlier/later vector pair over 0..31 with both flag values
        for (int s = -1; s < 32; s++) begin
            for (int t = 0; t < 32; t++) begin
                for (int sw = 0; sw < 2; sw++) begin
                    clear();
                    if (s >= 0) issue(s, 0, 32'hA500_0000 | 32'(s), 0, "");
                    issue(t, sw[0], 32'h5A00_0000 | 32'(t << 8) | 32'(sw), 0, "");
                    // R6/R7: a follow-up contributory reveals the remembered state
                    issue(11, 0, 32'h0000_0B0B, 0, "");
                end
            end
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule